// File: doc/BRIEF.md
# Gated Fractional Rate Divider

This block produces a one-cycle count-enable strobe for a PWM counter. It takes a stream of qualifying events and thins it by a fractional ratio made of an 8-bit whole part and a 4-bit sixteenths part. The ratio therefore runs from 1.0 up to 255.9375 in steps of 1/16.

A 2-bit source selector chooses what counts as an event. The choices are every system clock cycle, every clock cycle on which an external pin is high, every rising edge of that pin, or every falling edge of it. The pin is asynchronous to the clock and passes through a two-flop synchronizer inside the block before the level or edge is examined.

The fraction is handled by an accumulator kept in sixteenths. Each event adds 16. Whenever the sum reaches the divisor, the divisor is subtracted and a strobe is issued. Over a long run this gives exactly events × 16 / divisor strobes. A run enable holds the block idle and clears the accumulator while it is low.

Top module: `frac_rate_div`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `tick` is low, and the accumulator restarts from zero.
- R2: While `run_en` is low, `tick` stays low and the accumulator is cleared, so a later run starts from zero.
- R3: With divisor D = `div_int`×16 + `div_frac`, an accumulator starting at zero issues floor(E×16/D) strobes for E qualifying events. Each strobe is a single-cycle high pulse on `tick`.
- R4: With `src_mode` = 0 (free-running), every clock edge with `run_en` high is an event. A strobe is registered on the edge that takes the event, so with D = 16 `tick` is high in every cycle following an enabled edge.
- R5: A divisor below 1.0 (`div_int` = 0) behaves exactly like 1.0.
- R6: With `src_mode` = 1, an event is each clock edge at which the synchronized pin is high.
- R7: With `src_mode` = 2, an event is each low-to-high transition of the synchronized pin.
- R8: With `src_mode` = 3, an event is each high-to-low transition of the synchronized pin.
- R9: In the pin modes, a pin change sampled at clock edge k produces its strobe on edge k+2, visible after that edge. A pin held low yields no strobe in modes 1 and 2.
- R10: The largest divisor, 255.9375, is handled without overflow: 8190 free-running events give exactly 32 strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Run enable; low clears the accumulator |
| src_mode | input | 2 | Event source: 0 clock, 1 pin level, 2 pin rise, 3 pin fall |
| div_int | input | 8 | Whole part of the divisor |
| div_frac | input | 4 | Sixteenths part of the divisor |
| pin_raw | input | 1 | Asynchronous external pin |
| tick | output | 1 | Registered one-cycle count-enable strobe |

## Verification
In free-running mode a strobe is due one edge after the enabled edge that supplies the event. A pin change takes three edges to appear: two synchronizer flops and then the registered strobe. The bench drives inputs on falling edges and samples `tick` on the falling edge after the edge where it is due. It checks exactly one and three cycles after the stimulus for these latencies. For rate checks it counts strobes over a window that stays open a few cycles past the last event, so every in-flight strobe is counted before the enable drops.

// File: rtl/frac_rate_div_pkg.sv
package frac_rate_div_pkg;
  typedef enum logic [1:0] {
    SRC_CLOCK = 2'd0,
    SRC_LEVEL = 2'd1,
    SRC_RISE  = 2'd2,
    SRC_FALL  = 2'd3
  } src_mode_e;
endpackage

// File: rtl/frd_pin_sync.sv
module frd_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_raw,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_raw};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign level = sync_q[STAGES-1];
  assign rise  = sync_q[STAGES-1] & ~prev_q;
  assign fall  = ~sync_q[STAGES-1] & prev_q;
endmodule

// File: rtl/frd_event_sel.sv
module frd_event_sel
  import frac_rate_div_pkg::*;
(
  input  logic [1:0] src_mode,
  input  logic       level,
  input  logic       rise,
  input  logic       fall,
  output logic       event_hit
);
  always_comb begin
    case (src_mode_e'(src_mode))
      SRC_CLOCK: event_hit = 1'b1;
      SRC_LEVEL: event_hit = level;
      SRC_RISE:  event_hit = rise;
      SRC_FALL:  event_hit = fall;
      default:   event_hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/frd_accum.sv
module frd_accum #(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_en,
  input  logic              event_hit,
  input  logic [INT_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] div_frac,
  output logic              tick
);
  localparam int DIV_W = INT_W + FRAC_W;
  localparam int ACC_W = DIV_W + 1;
  localparam logic [ACC_W-1:0] UNIT = ACC_W'(1) << FRAC_W;

  logic [ACC_W-1:0] div_eff;
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] sum;

  // Divisors below one whole unit are raised to exactly one unit.
  always_comb begin
    if (div_int == '0) div_eff = UNIT;
    else               div_eff = {1'b0, div_int, div_frac};
  end

  assign sum = acc_q + UNIT;

  always_ff @(posedge clk) begin
    if (rst || !run_en) begin
      acc_q <= '0;
      tick  <= 1'b0;
    end else if (event_hit) begin
      if (sum >= div_eff) begin
        acc_q <= sum - div_eff;
        tick  <= 1'b1;
      end else begin
        acc_q <= sum;
        tick  <= 1'b0;
      end
    end else begin
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/frac_rate_div.sv
module frac_rate_div #(
  parameter int INT_W       = 8,
  parameter int FRAC_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_en,
  input  logic [1:0]        src_mode,
  input  logic [INT_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] div_frac,
  input  logic              pin_raw,
  output logic              tick
);
  logic pin_level, pin_rise, pin_fall, event_hit;

  frd_pin_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .pin_raw(pin_raw),
    .level(pin_level), .rise(pin_rise), .fall(pin_fall)
  );

  frd_event_sel sel_i (
    .src_mode(src_mode), .level(pin_level), .rise(pin_rise),
    .fall(pin_fall), .event_hit(event_hit)
  );

  frd_accum #(.INT_W(INT_W), .FRAC_W(FRAC_W)) acc_i (
    .clk(clk), .rst(rst), .run_en(run_en), .event_hit(event_hit),
    .div_int(div_int), .div_frac(div_frac), .tick(tick)
  );
endmodule

// File: rtl/frac_rate_div_chk.sv
module frac_rate_div_chk #(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              run_en,
  input logic [1:0]        src_mode,
  input logic [INT_W-1:0]  div_int,
  input logic [FRAC_W-1:0] div_frac,
  input logic              pin_raw,
  input logic              tick
);
  // R1: a reset edge leaves the strobe low
  a_r1_tick_low_after_reset: assert property (@(posedge clk)
    rst |=> !tick);

  // R2: a disabled edge never yields a strobe
  a_r2_no_tick_disabled: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> !tick);

  // R4: unity divisor in free-running mode strobes after every enabled edge
  a_r4_unity_every_cycle: assert property (@(posedge clk) disable iff (rst)
    (run_en && src_mode == 2'd0 && div_int == INT_W'(1) && div_frac == '0) |=> tick);

  // R9: level and rise modes need the pin high three edges back
  a_r9_pin_low_no_tick: assert property (@(posedge clk) disable iff (rst)
    (($past(src_mode) == 2'd1 || $past(src_mode) == 2'd2) && !$past(pin_raw, 3)) |-> !tick);
endmodule

bind frac_rate_div frac_rate_div_chk #(.INT_W(INT_W), .FRAC_W(FRAC_W)) chk_i (
  .clk(clk), .rst(rst), .run_en(run_en), .src_mode(src_mode),
  .div_int(div_int), .div_frac(div_frac), .pin_raw(pin_raw), .tick(tick)
);

// File: tb/frac_rate_div_tb_top.sv
module frac_rate_div_tb_top;
  localparam time CLK_P = 8ns;
  localparam int  NV    = 11;

  // mode, whole, sixteenths, count (cycles or pulses), pulse width
  localparam int V_MODE [NV] = '{0, 0, 0, 0, 0, 1, 1, 2, 2, 3, 3};
  localparam int V_INT  [NV] = '{1, 3, 2, 0, 255, 2, 1, 1, 2, 1, 3};
  localparam int V_FRAC [NV] = '{0, 0, 8, 0, 15, 0, 4, 0, 0, 8, 0};
  localparam int V_CNT  [NV] = '{20, 30, 25, 10, 8190, 5, 4, 6, 7, 9, 6};
  localparam int V_HI   [NV] = '{0, 0, 0, 0, 0, 3, 2, 2, 1, 3, 2};

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       run_en = 1'b0;
  logic [1:0] src_mode = 2'd0;
  logic [7:0] div_int = 8'd1;
  logic [3:0] div_frac = 4'd0;
  logic       pin_raw = 1'b0;
  logic       tick;

  int checks = 0;
  int errors = 0;
  int tick_cnt = 0;
  bit counting = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  frac_rate_div dut_i (
    .clk(clk), .rst(rst), .run_en(run_en), .src_mode(src_mode),
    .div_int(div_int), .div_frac(div_frac), .pin_raw(pin_raw), .tick(tick)
  );

  always @(negedge clk) if (counting && tick) tick_cnt++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic int exp_ticks(input int e, input int wi, input int fr);
    int d;
    d = wi * 16 + fr;
    if (wi == 0) d = 16;   // R5: below one unit acts as one unit
    return (e * 16) / d;
  endfunction

  task automatic run_vec(input int m, input int wi, input int fr, input int cnt, input int hi);
    int ev;
    run_en = 1'b0; pin_raw = 1'b0;
    src_mode = 2'(m); div_int = 8'(wi); div_frac = 4'(fr);
    cyc(4);
    tick_cnt = 0; counting = 1'b1;
    if (m == 0) begin
      run_en = 1'b1; cyc(cnt); run_en = 1'b0; cyc(3);
      ev = cnt;
    end else begin
      run_en = 1'b1;
      for (int p = 0; p < cnt; p++) begin
        pin_raw = 1'b1; cyc(hi);
        pin_raw = 1'b0; cyc(2);
      end
      cyc(5); run_en = 1'b0; cyc(2);
      ev = (m == 1) ? cnt * hi : cnt;
    end
    counting = 1'b0;
    case (m)
      0: chk("R3 R4 R10 free-running rate", tick_cnt, exp_ticks(ev, wi, fr));
      1: chk("R6 pin level rate", tick_cnt, exp_ticks(ev, wi, fr));
      2: chk("R7 pin rise rate", tick_cnt, exp_ticks(ev, wi, fr));
      default: chk("R8 pin fall rate", tick_cnt, exp_ticks(ev, wi, fr));
    endcase
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    chk("R1 tick low in reset", int'(tick), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 tick low after reset", int'(tick), 0);

    // table walk
    for (int v = 0; v < NV; v++)
      run_vec(V_MODE[v], V_INT[v], V_FRAC[v], V_CNT[v], V_HI[v]);

    // R2: disabled free-running produces nothing
    src_mode = 2'd0; div_int = 8'd1; div_frac = 4'd0; run_en = 1'b0;
    tick_cnt = 0; counting = 1'b1; cyc(20); counting = 1'b0;
    chk("R2 no tick while disabled", tick_cnt, 0);

    // R2: accumulator cleared by disable; div 3 needs 3 fresh events
    div_int = 8'd3;
    run_en = 1'b1; cyc(2); run_en = 1'b0; cyc(2);
    tick_cnt = 0; counting = 1'b1;
    run_en = 1'b1; cyc(2); run_en = 1'b0; cyc(2);
    counting = 1'b0;
    chk("R2 accumulator restarts from zero", tick_cnt, 0);

    // R4: unity latency, strobe one cycle after enable edge
    div_int = 8'd1;
    @(negedge clk); run_en = 1'b1;
    chk("R4 tick before enabled edge", int'(tick), 0);
    @(negedge clk);
    chk("R4 tick one cycle after enabled edge", int'(tick), 1);
    run_en = 1'b0; cyc(2);

    // R9: pin rise latency is three edges
    src_mode = 2'd2; pin_raw = 1'b0; run_en = 1'b1; cyc(3);
    pin_raw = 1'b1;
    @(negedge clk); chk("R9 rise edge+1 no tick", int'(tick), 0);
    @(negedge clk); chk("R9 rise edge+2 no tick", int'(tick), 0);
    @(negedge clk); chk("R9 rise edge+3 tick", int'(tick), 1);
    @(negedge clk); chk("R7 single strobe per rise", int'(tick), 0);
    pin_raw = 1'b0; cyc(3);

    // R9: pin held low in level mode gives no strobe
    src_mode = 2'd1;
    tick_cnt = 0; counting = 1'b1; cyc(15); counting = 1'b0;
    chk("R9 pin low level mode no tick", tick_cnt, 0);

    // R5: divisor 0.5 acts as 1.0
    src_mode = 2'd0; run_en = 1'b0; div_int = 8'd0; div_frac = 4'd8; cyc(2);
    tick_cnt = 0; counting = 1'b1;
    run_en = 1'b1; cyc(12); run_en = 1'b0; cyc(3);
    counting = 1'b0;
    chk("R5 sub-unit divisor acts as 1.0", tick_cnt, 12);

    // R1: mid-run reset drops the strobe
    div_int = 8'd1; div_frac = 4'd0; run_en = 1'b1; cyc(3);
    rst = 1'b1; @(negedge clk);
    chk("R1 reset clears tick", int'(tick), 0);
    rst = 1'b0; run_en = 1'b0; cyc(2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule